// File: doc/BRIEF.md
# Calendar Clock Core with Alarm Compare

This core keeps wall-clock time and date in byte-wide registers: seconds, minutes, hours, day of week, day of month, month and two-digit year. It also holds an alarm byte for each of seconds, minutes and hours. The system supplies a one-cycle pulse once per second. On each pulse the core raises an update-in-progress flag, waits a fixed number of core cycles, and then moves the whole calendar forward by one second in a single edge. Seconds carry into minutes, minutes into hours, hours into days, days into months and months into years.

The host reaches every register through a byte-wide port with a 4-bit index. It reads combinationally and writes on a one-cycle strobe. A control byte chooses BCD or binary coding and 12- or 24-hour format. The same byte has a freeze bit: while it is set, updates are held off so the host can load a consistent time. Two one-cycle outputs mark the end of each update and an alarm match at that update.

Top module: `rtc_calendar_core`

## Requirements
- R1: Register indices: 0 seconds, 1 seconds alarm, 2 minutes, 3 minutes alarm, 4 hours, 5 hours alarm, 6 day of week, 7 day of month, 8 month, 9 year, 10–13 control A–D. After reset:
  - all time and alarm bytes read 0, except day of month 1 and month 1;
  - control B reads 0x02 (BCD, 24-hour);
  - control A reads 0x00;
  - control C reads 0x00;
  - control D reads 0x80.
- R2: A tick while idle and not frozen raises `uip_o`, which is also bit 7 of control A, on the next cycle. The flag stays high for exactly UIP_LEAD cycles. The calendar changes on the same edge at which the flag falls. Ticks that arrive while the flag is high are ignored.
- R3: With control B bit 2 clear, every field is coded in BCD.
  - Seconds and minutes wrap from 59 to 0.
  - Hours wrap from 23 to 0 in 24-hour mode (control B bit 1 set).
  - Each wrap carries into the next field.
- R4: With control B bit 2 set, every field is held and counted as plain binary, with the same limits as R3.
- R5: With control B bit 1 clear, hours run 1–12 and hours bit 7 set means PM.
  - 11:59:59 AM steps to 12:00:00 PM.
  - 12:59:59 steps to 1 of the same half.
  - 11:59:59 PM steps to 12 AM and carries into the day.
- R6: Day of month wraps to 1 after 30 days in months 4, 6, 9 and 11, and after 31 days in the other months except February.
  - February has 29 days when the year is divisible by 4, otherwise 28.
  - Month wraps from 12 to 1 and carries into the year.
  - Year wraps from 99 to 0.
- R7: On a day carry, a day of week of 0 stays 0, 1–6 increment, and 7 becomes 1.
- R8: While control B bit 7 (freeze) is set:
  - no update starts;
  - an update already waiting is cancelled without changing the calendar;
  - host writes to time registers are kept.
- R9: Host writes to time registers while freeze is clear are accepted and read back.
- R10: `upd_done_o` is high for exactly one cycle after every update, the first cycle in which `uip_o` is low again.
- R11: `alarm_o` pulses together with `upd_done_o` when the new seconds, minutes and hours each equal their alarm byte. An alarm byte whose bits 7:6 are both 1 matches any value.
- R12: Writes to control A, C and D have no effect. Control D always reads 0x80, and control C and unused indices 14–15 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| bus_addr | input | 4 | Register index for read and write |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| uip_o | output | 1 | Update in progress |
| upd_done_o | output | 1 | One-cycle pulse when an update has completed |
| alarm_o | output | 1 | One-cycle pulse when an update matches the alarm |

## Verification
The assertions check the update sequence on every cycle:
- an update-done pulse always ends an in-progress window of exactly the configured length and is never longer than one cycle;
- an alarm pulse never appears without an update;
- freezing forces the in-progress flag low;
- seconds never change without a preceding in-progress window or a host write to that register.

Only the bench scenarios can show that the calendar arithmetic is right:
- carry chains through month ends in leap and ordinary years;
- 12-hour AM/PM transitions in both codings;
- day-of-week behaviour;
- the don't-care alarm coding;
- cancellation of a waiting update by the freeze bit.

// File: rtl/rtc_pkg.sv
// Shared definitions for the calendar clock core: register indices,
// control bit positions, the calendar record and the coding helpers.
// Assumes two-digit years and byte-wide fields.
package rtc_pkg;

    localparam int unsigned ADDR_W = 4;
    localparam int unsigned BYTE_W = 8;

    localparam logic [ADDR_W-1:0] IDX_SEC      = 4'd0;
    localparam logic [ADDR_W-1:0] IDX_SEC_ALM  = 4'd1;
    localparam logic [ADDR_W-1:0] IDX_MIN      = 4'd2;
    localparam logic [ADDR_W-1:0] IDX_MIN_ALM  = 4'd3;
    localparam logic [ADDR_W-1:0] IDX_HOUR     = 4'd4;
    localparam logic [ADDR_W-1:0] IDX_HOUR_ALM = 4'd5;
    localparam logic [ADDR_W-1:0] IDX_WDAY     = 4'd6;
    localparam logic [ADDR_W-1:0] IDX_MDAY     = 4'd7;
    localparam logic [ADDR_W-1:0] IDX_MONTH    = 4'd8;
    localparam logic [ADDR_W-1:0] IDX_YEAR     = 4'd9;
    localparam logic [ADDR_W-1:0] IDX_CTL_A    = 4'd10;
    localparam logic [ADDR_W-1:0] IDX_CTL_B    = 4'd11;
    localparam logic [ADDR_W-1:0] IDX_CTL_C    = 4'd12;
    localparam logic [ADDR_W-1:0] IDX_CTL_D    = 4'd13;

    localparam int unsigned BIT_FREEZE = 7;
    localparam int unsigned BIT_BINARY = 2;
    localparam int unsigned BIT_H24    = 1;

    localparam logic [BYTE_W-1:0] CTL_B_RESET = 8'h02;
    localparam logic [BYTE_W-1:0] VALID_BYTE  = 8'h80;

    typedef struct packed {
        logic [BYTE_W-1:0] sec;
        logic [BYTE_W-1:0] min;
        logic [BYTE_W-1:0] hour;
        logic [BYTE_W-1:0] wday;
        logic [BYTE_W-1:0] mday;
        logic [BYTE_W-1:0] month;
        logic [BYTE_W-1:0] year;
    } cal_t;

    // Register byte to plain number (BCD decoded unless binary)
    function automatic logic [7:0] to_num(input logic [7:0] v, input logic bin);
        return bin ? v : (8'(v[7:4]) * 8'd10 + 8'(v[3:0]));
    endfunction

    // Plain number (< 100) to register byte
    function automatic logic [7:0] from_num(input logic [7:0] n, input logic bin);
        return bin ? n : (((n / 8'd10) << 4) | (n % 8'd10));
    endfunction

    // Hours byte to 0..23
    function automatic logic [7:0] hour_to_num(input logic [7:0] v, input logic bin,
                                               input logic h24);
        logic [7:0] h;
        if (h24) begin
            h = to_num(v, bin);
        end else begin
            h = to_num({1'b0, v[6:0]}, bin);
            if (h == 8'd12) h = 8'd0;
            if (v[7]) h = h + 8'd12;
        end
        return h;
    endfunction

    // 0..23 to hours byte
    function automatic logic [7:0] hour_from_num(input logic [7:0] n, input logic bin,
                                                 input logic h24);
        logic [7:0] h;
        logic       pm;
        if (h24) begin
            return from_num(n, bin);
        end
        pm = (n >= 8'd12);
        h  = pm ? (n - 8'd12) : n;
        if (h == 8'd0) h = 8'd12;
        return (pm ? 8'h80 : 8'h00) | from_num(h, bin);
    endfunction

    // Days in a month; low two year bits give the leap rule
    function automatic logic [7:0] days_in(input logic [7:0] m, input logic [1:0] y_lo);
        case (m)
            8'd2:                      return (y_lo == 2'b00) ? 8'd29 : 8'd28;
            8'd4, 8'd6, 8'd9, 8'd11:   return 8'd30;
            default:                   return 8'd31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_update_seq.sv
// Update sequencer: on a tick it raises the in-progress flag, holds it for
// LEAD cycles and then issues a one-cycle advance strobe as it drops the flag.
// Freeze cancels a waiting update and blocks new ones. Assumes LEAD >= 1.
module rtc_update_seq #(
    parameter int unsigned LEAD = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic freeze,
    output logic busy,
    output logic advance
);
    localparam int unsigned CW = $clog2(LEAD) + 1;

    typedef enum logic {ST_IDLE, ST_WAIT} st_t;

    st_t           st_q;
    logic [CW-1:0] cnt_q;

    // Waiting state and lead counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: if (tick && !freeze) begin
                    st_q  <= ST_WAIT;
                    cnt_q <= CW'(LEAD - 1);
                end
                ST_WAIT: begin
                    if (freeze || cnt_q == '0) st_q <= ST_IDLE;
                    else                       cnt_q <= cnt_q - 1'b1;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Flag and strobe decode
    always_comb begin
        busy    = (st_q == ST_WAIT);
        advance = busy && (cnt_q == '0) && !freeze;
    end

endmodule

// File: rtl/rtc_time_step.sv
// Combinational one-second step of the calendar record in the selected
// coding and hour format. Out-of-range loaded values wrap at the next carry.
module rtc_time_step
    import rtc_pkg::*;
(
    input  cal_t cur,
    input  logic bin_mode,
    input  logic h24,
    output cal_t nxt
);
    logic [7:0] s, m, h, d, mo, y;
    logic [7:0] ns, nm, nh, nd, nmo, ny, nwd;
    logic       c_min, c_hour, c_day;

    // Decode, carry chain, encode
    always_comb begin
        s  = to_num(cur.sec, bin_mode);
        m  = to_num(cur.min, bin_mode);
        h  = hour_to_num(cur.hour, bin_mode, h24);
        d  = to_num(cur.mday, bin_mode);
        mo = to_num(cur.month, bin_mode);
        y  = to_num(cur.year, bin_mode);

        c_min  = (s >= 8'd59);
        ns     = c_min ? 8'd0 : s + 8'd1;
        c_hour = c_min && (m >= 8'd59);
        nm     = c_min ? (c_hour ? 8'd0 : m + 8'd1) : m;
        c_day  = c_hour && (h >= 8'd23);
        nh     = c_hour ? (c_day ? 8'd0 : h + 8'd1) : h;

        nd  = d;
        nmo = mo;
        ny  = y;
        nwd = cur.wday;
        if (c_day) begin
            if (cur.wday != 8'd0) nwd = (cur.wday >= 8'd7) ? 8'd1 : cur.wday + 8'd1;
            if (d >= days_in(mo, y[1:0])) begin
                nd = 8'd1;
                if (mo >= 8'd12) begin
                    nmo = 8'd1;
                    ny  = (y >= 8'd99) ? 8'd0 : y + 8'd1;
                end else begin
                    nmo = mo + 8'd1;
                end
            end else begin
                nd = d + 8'd1;
            end
        end

        nxt.sec   = from_num(ns, bin_mode);
        nxt.min   = from_num(nm, bin_mode);
        nxt.hour  = hour_from_num(nh, bin_mode, h24);
        nxt.wday  = nwd;
        nxt.mday  = from_num(nd, bin_mode);
        nxt.month = from_num(nmo, bin_mode);
        nxt.year  = from_num(ny, bin_mode);
    end

endmodule

// File: rtl/rtc_alarm_match.sv
// Compares NF time bytes with their alarm bytes. An alarm byte whose two
// top bits are set is a wildcard. Bytes are compared in register coding.
module rtc_alarm_match #(
    parameter int unsigned NF = 3
) (
    input  logic [NF-1:0][7:0] now_f,
    input  logic [NF-1:0][7:0] alm_f,
    output logic               hit
);
    logic [NF-1:0] fhit;

    for (genvar i = 0; i < NF; i++) begin : g_field
        // Per-field equality or wildcard
        assign fhit[i] = (alm_f[i][7:6] == 2'b11) || (alm_f[i] == now_f[i]);
    end

    assign hit = &fhit;

endmodule

// File: rtl/rtc_calendar_core.sv
// Calendar clock core: register file, host port, update sequencing and
// pulse outputs. Assumes tick_1hz is a clean one-cycle pulse and that
// UIP_LEAD core cycles stand for the lead time before each update.
module rtc_calendar_core
    import rtc_pkg::*;
#(
    parameter int unsigned UIP_LEAD = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              uip_o,
    output logic              upd_done_o,
    output logic              alarm_o
);
    localparam int unsigned N_ALM = 3;

    cal_t              cal_q;
    cal_t              cal_nxt;
    logic [BYTE_W-1:0] alm_sec_q, alm_min_q, alm_hour_q;
    logic [BYTE_W-1:0] ctl_q;
    logic              freeze, bin_mode, h24;
    logic              busy, advance, alm_hit;

    assign freeze   = ctl_q[BIT_FREEZE];
    assign bin_mode = ctl_q[BIT_BINARY];
    assign h24      = ctl_q[BIT_H24];

    rtc_update_seq #(.LEAD(UIP_LEAD)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_1hz),
        .freeze  (freeze),
        .busy    (busy),
        .advance (advance)
    );

    rtc_time_step u_step (
        .cur      (cal_q),
        .bin_mode (bin_mode),
        .h24      (h24),
        .nxt      (cal_nxt)
    );

    rtc_alarm_match #(.NF(N_ALM)) u_alm (
        .now_f ({cal_nxt.hour, cal_nxt.min, cal_nxt.sec}),
        .alm_f ({alm_hour_q, alm_min_q, alm_sec_q}),
        .hit   (alm_hit)
    );

    // Time registers: update wins over a host write on the same edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cal_q       <= '0;
            cal_q.mday  <= 8'd1;
            cal_q.month <= 8'd1;
        end else if (advance) begin
            cal_q <= cal_nxt;
        end else if (bus_wr) begin
            case (bus_addr)
                IDX_SEC:   cal_q.sec   <= bus_wdata;
                IDX_MIN:   cal_q.min   <= bus_wdata;
                IDX_HOUR:  cal_q.hour  <= bus_wdata;
                IDX_WDAY:  cal_q.wday  <= bus_wdata;
                IDX_MDAY:  cal_q.mday  <= bus_wdata;
                IDX_MONTH: cal_q.month <= bus_wdata;
                IDX_YEAR:  cal_q.year  <= bus_wdata;
                default: ;
            endcase
        end
    end

    // Alarm and mode registers: host writes only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alm_sec_q  <= '0;
            alm_min_q  <= '0;
            alm_hour_q <= '0;
            ctl_q      <= CTL_B_RESET;
        end else if (bus_wr) begin
            case (bus_addr)
                IDX_SEC_ALM:  alm_sec_q  <= bus_wdata;
                IDX_MIN_ALM:  alm_min_q  <= bus_wdata;
                IDX_HOUR_ALM: alm_hour_q <= bus_wdata;
                IDX_CTL_B:    ctl_q      <= bus_wdata;
                default: ;
            endcase
        end
    end

    // Completion and alarm pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_done_o <= 1'b0;
            alarm_o    <= 1'b0;
        end else begin
            upd_done_o <= advance;
            alarm_o    <= advance && alm_hit;
        end
    end

    // Host read mux
    always_comb begin
        case (bus_addr)
            IDX_SEC:      bus_rdata = cal_q.sec;
            IDX_SEC_ALM:  bus_rdata = alm_sec_q;
            IDX_MIN:      bus_rdata = cal_q.min;
            IDX_MIN_ALM:  bus_rdata = alm_min_q;
            IDX_HOUR:     bus_rdata = cal_q.hour;
            IDX_HOUR_ALM: bus_rdata = alm_hour_q;
            IDX_WDAY:     bus_rdata = cal_q.wday;
            IDX_MDAY:     bus_rdata = cal_q.mday;
            IDX_MONTH:    bus_rdata = cal_q.month;
            IDX_YEAR:     bus_rdata = cal_q.year;
            IDX_CTL_A:    bus_rdata = {busy, 7'd0};
            IDX_CTL_B:    bus_rdata = ctl_q;
            IDX_CTL_D:    bus_rdata = VALID_BYTE;
            default:      bus_rdata = '0;
        endcase
    end

    assign uip_o = busy;

endmodule

// File: rtl/rtc_calendar_checker.sv
// Cycle-level properties of the calendar core's update sequence, bound to
// every instance of the top module. Watches ports and the freeze and
// seconds state.
module rtc_calendar_checker #(
    parameter int unsigned LEAD = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       uip,
    input logic       upd_done,
    input logic       alarm,
    input logic       freeze,
    input logic       host_wr,
    input logic [3:0] host_addr,
    input logic [7:0] sec_now
);
    logic [31:0] run_q;

    // Length of the current or just-ended in-progress window
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= uip ? run_q + 32'd1 : 32'd0;
    end

    AST_UIP_LEAD_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        upd_done |-> (run_q == LEAD)); // R2

    AST_SEC_NEEDS_UIP: assert property (@(posedge clk) disable iff (!rst_n)
        ((sec_now != $past(sec_now)) && !($past(host_wr) && ($past(host_addr) == 4'd0)))
        |-> $past(uip)); // R2

    AST_DONE_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        upd_done |-> $fell(uip)); // R10

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        upd_done |=> !upd_done); // R10

    AST_ALARM_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        alarm |-> upd_done); // R11

    AST_FREEZE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(freeze) |-> !uip); // R8

endmodule

bind rtc_calendar_core rtc_calendar_checker #(.LEAD(UIP_LEAD)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .uip       (uip_o),
    .upd_done  (upd_done_o),
    .alarm     (alarm_o),
    .freeze    (ctl_q[7]),
    .host_wr   (bus_wr),
    .host_addr (bus_addr),
    .sec_now   (cal_q.sec)
);

// File: tb/rtc_calendar_core_tb.sv
// Sweeps the calendar core through second runs, all hours in 12-hour mode,
// every month end in leap and ordinary years, alarms, freeze and busy ticks.
// Expected values come from an arithmetic model kept in the bench.
module rtc_calendar_core_tb;
    localparam int LEAD = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1hz = 1'b0;
    logic [3:0] bus_addr = 4'd0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       uip_o, upd_done_o, alarm_o;

    int checks = 0;
    int errors = 0;
    int done_cnt = 0;
    int uip_cnt = 0;

    // Bench model state (plain numbers) and mode
    int es, em, eh, ewd, emd, emo, ey;
    int as_b, am_b, ah_b;
    bit bmode, h24;

    rtc_calendar_core #(.UIP_LEAD(LEAD)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_1hz   (tick_1hz),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .uip_o      (uip_o),
        .upd_done_o (upd_done_o),
        .alarm_o    (alarm_o)
    );

    always #5 clk = ~clk;

    always @(negedge clk) begin
        if (upd_done_o) done_cnt++;
        if (uip_o) uip_cnt++;
    end

    initial begin
        #2000000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got 0x%0h exp 0x%0h", tag, got, exp);
        end
    endtask

    function automatic int enc(input int n);
        return bmode ? n : ((n / 10) * 16 + (n % 10));
    endfunction

    function automatic int enc_h(input int n);
        int h;
        if (h24) return enc(n);
        h = n % 12;
        if (h == 0) h = 12;
        return (n >= 12 ? 128 : 0) + enc(h);
    endfunction

    function automatic int mdays(input int m, input int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    function automatic int a_hit(input int raw, input int alm);
        return ((alm / 64) == 3 || raw == alm) ? 1 : 0;
    endfunction

    task automatic model_step();
        es++;
        if (es >= 60) begin
            es = 0; em++;
            if (em >= 60) begin
                em = 0; eh++;
                if (eh >= 24) begin
                    eh = 0;
                    if (ewd != 0) ewd = (ewd == 7) ? 1 : ewd + 1;
                    emd++;
                    if (emd > mdays(emo, ey)) begin
                        emd = 1; emo++;
                        if (emo > 12) begin
                            emo = 1;
                            ey = (ey + 1) % 100;
                        end
                    end
                end
            end
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_addr = 4'(a);
        bus_wdata = 8'(d);
        bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        bus_addr = 4'(a);
        #1;
        v = int'(bus_rdata);
    endtask

    function automatic int ctl_byte(input bit frz);
        return (frz ? 128 : 0) + (bmode ? 4 : 0) + (h24 ? 2 : 0);
    endfunction

    task automatic load_all();
        wr(11, ctl_byte(1'b1));
        wr(0, enc(es));
        wr(2, enc(em));
        wr(4, enc_h(eh));
        wr(6, ewd);
        wr(7, enc(emd));
        wr(8, enc(emo));
        wr(9, enc(ey));
        wr(1, as_b);
        wr(3, am_b);
        wr(5, ah_b);
        wr(11, ctl_byte(1'b0));
    endtask

    task automatic check_time(input string tg);
        int v;
        rd(0, v); chk({tg, " sec"}, v, enc(es));
        rd(2, v); chk({tg, " min"}, v, enc(em));
        rd(4, v); chk({tg, " hour"}, v, enc_h(eh));
        rd(6, v); chk({tg, " wday R7"}, v, ewd);
        rd(7, v); chk({tg, " mday R6"}, v, enc(emd));
        rd(8, v); chk({tg, " month R6"}, v, enc(emo));
        rd(9, v); chk({tg, " year R6"}, v, enc(ey));
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        tick_1hz = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0;
    endtask

    task automatic step(input string tg);
        int n;
        pulse_tick();
        n = 0;
        while (uip_o === 1'b1 && n < 100) begin
            n++;
            @(negedge clk);
        end
        chk("R2 uip high cycles", n, LEAD);
        chk("R10 done pulse at uip fall", int'(upd_done_o), 1);
        model_step();
        chk("R11 alarm pulse", int'(alarm_o),
            a_hit(enc(es), as_b) & a_hit(enc(em), am_b) & a_hit(enc_h(eh), ah_b));
        @(negedge clk);
        chk("R10 done width", int'(upd_done_o), 0);
        check_time(tg);
    endtask

    task automatic set_time(input int h, input int m, input int s, input int wd,
                            input int md, input int mo, input int y);
        eh = h; em = m; es = s; ewd = wd; emd = md; emo = mo; ey = y;
        load_all();
    endtask

    initial begin
        int v, d0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(0, v);  chk("R1 sec", v, 0);
        rd(1, v);  chk("R1 sec alarm", v, 0);
        rd(2, v);  chk("R1 min", v, 0);
        rd(4, v);  chk("R1 hour", v, 0);
        rd(5, v);  chk("R1 hour alarm", v, 0);
        rd(6, v);  chk("R1 wday", v, 0);
        rd(7, v);  chk("R1 mday", v, 1);
        rd(8, v);  chk("R1 month", v, 1);
        rd(9, v);  chk("R1 year", v, 0);
        rd(10, v); chk("R1 ctl A", v, 0);
        rd(11, v); chk("R1 ctl B", v, 2);
        rd(12, v); chk("R1 ctl C", v, 0);
        rd(13, v); chk("R1 ctl D", v, 128);

        // R12 writes to A, C, D ignored
        wr(10, 8'h7F); wr(12, 8'hFF); wr(13, 8'h00); wr(14, 8'hFF);
        rd(10, v); chk("R12 ctl A", v, 0);
        rd(12, v); chk("R12 ctl C", v, 0);
        rd(13, v); chk("R12 ctl D", v, 128);
        rd(14, v); chk("R12 unused", v, 0);

        // R9 write while running
        wr(2, 8'h37);
        rd(2, v); chk("R9 min readback", v, 8'h37);

        // R3 BCD 24-hour sweep across midnight and year end
        bmode = 0; h24 = 1;
        as_b = 8'h30; am_b = 8'hC1; ah_b = 8'hC0;
        set_time(23, 58, 50, 7, 31, 12, 99);
        for (int i = 0; i < 130; i++) step("R3 bcd sweep");

        // R4 binary sweep across leap day, wday 0 held
        bmode = 1; h24 = 1;
        as_b = 8'hD0; am_b = 0; ah_b = 0;
        set_time(23, 58, 50, 0, 28, 2, 24);
        for (int i = 0; i < 130; i++) step("R4 bin sweep");

        // R5 every hour wrap in 12-hour mode, both codings
        as_b = 8'hFF; am_b = 8'hFF; ah_b = 8'h12;
        for (int b = 0; b < 2; b++) begin
            bmode = b[0]; h24 = 0;
            for (int h = 0; h < 24; h++) begin
                set_time(h, 59, 59, 3, 15, 6, 10);
                step("R5 12h hour wrap");
            end
        end

        // R6 month ends in leap and ordinary years, both codings
        as_b = 0; am_b = 0; ah_b = 0;
        for (int b = 0; b < 2; b++) begin
            bmode = b[0]; h24 = 1;
            for (int m = 1; m <= 12; m++) begin
                for (int y = 23; y <= 24; y++) begin
                    set_time(23, 59, 59, 6, mdays(m, y), m, y);
                    step("R6 month end");
                end
            end
        end

        // R2 ticks during an update are ignored
        bmode = 0; h24 = 1;
        set_time(10, 20, 30, 1, 5, 5, 5);
        d0 = done_cnt;
        pulse_tick();
        pulse_tick();
        repeat (2 * LEAD + 6) @(negedge clk);
        rd(0, v); chk("R2 busy tick ignored sec", v, 8'h31);
        chk("R2 busy tick one done", done_cnt - d0, 1);

        // R8 freeze blocks updates and keeps host writes
        wr(11, 8'h82);
        d0 = done_cnt;
        v = uip_cnt;
        pulse_tick();
        repeat (LEAD + 4) @(negedge clk);
        chk("R8 no uip while frozen", uip_cnt - v, 0);
        chk("R8 no done while frozen", done_cnt - d0, 0);
        rd(0, v); chk("R8 sec held", v, 8'h31);
        wr(0, 8'h45);
        rd(0, v); chk("R8 frozen write kept", v, 8'h45);

        // R8 freeze cancels a waiting update
        wr(11, 8'h02);
        d0 = done_cnt;
        pulse_tick();
        wr(11, 8'h82);
        repeat (LEAD + 4) @(negedge clk);
        chk("R8 cancelled no done", done_cnt - d0, 0);
        rd(0, v); chk("R8 cancelled sec", v, 8'h45);
        rd(10, v); chk("R2 ctl A idle", v, 0);

        // Resume after freeze
        wr(11, 8'h02);
        es = 45; em = 20; eh = 10; ewd = 1; emd = 5; emo = 5; ey = 5;
        as_b = 0; am_b = 0; ah_b = 0;
        step("R8 resume");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule